// File: doc/BRIEF.md
# Event Timer Main Counter and Global Register Block

This block is the shared front end of a multi-channel event-timer peripheral. It owns the free-running 64-bit main counter, the read-only capability words, the global configuration word, and the interrupt status word. All of them are reached through a 32-bit register port that spans a 1 KB window. The block also decodes the per-channel register windows and steers those accesses to the channel logic. That channel logic is kept outside the block, and so are the comparators and the interrupt pin routing.

The counter advances by one on each cycle in which the `tick` enable is high while the global enable is set. Clearing the global enable freezes the counter. Setting it again resumes counting from the frozen value and sends a one-cycle re-arm request to every channel whose comparator is not all ones. Software can load either 32-bit half of the counter at any time. Channels report events through `chan_irq_set`. Software clears the resulting status bits by writing ones to the status word.

Top module: `evtmr_global_regs`

## Requirements
- R1: After reset the counter, the configuration word (bit 0 enable, bit 1 legacy route) and the status word read as zero, and `count_en`, `legacy_route`, `chan_rearm` and `chan_irq_clr` are low.
- R2: While enabled, the counter increases by exactly one on every clock edge at which `tick` is high, with the carry running from the low half (offset 0x0F0) into the high half (offset 0x0F4).
- R3: While the enable is clear, the counter holds its value whatever `tick` does. Reads return that held value, and counting resumes from it once the enable is set again.
- R4: A write to either counter half replaces that half and keeps the other half. On that edge the write takes priority over a tick.
- R5: A write to the status word (offset 0x020) clears each bit that is written as 1 and currently set, and it pulses the matching `chan_irq_clr` bit for one cycle. If a set request and a clear arrive for the same bit in the same cycle, the bit ends up set.
- R6: Clearing the enable clears the whole status word and pulses `chan_irq_clr` for each bit that was set. Set requests that arrive while the block is disabled are ignored.
- R7: Aligned accesses to offsets 0x100 to 0x3FF select channel (offset-0x100)/0x20 through a one-hot `chan_sel`, with `chan_word` equal to offset bits 4:2. Reads return that channel's `chan_rdata` slice. A channel index at or above the clamped timer count (at least 3, at most 24) selects nothing and reads as zero.
- R8: When a configuration write sets the enable, `chan_rearm` pulses for one cycle on the next cycle, for exactly the channels whose `chan_cmp_max` is low.
- R9: Offset 0x000 reads {VENDOR_ID[15:0], legacy-capable=1 at bit 15, 64-bit counter=1 at bit 13, timer count minus one at bits 12:8, REVISION at bits 7:0}, and offset 0x004 reads the tick period in femtoseconds. Writes to both are ignored, and offset 0x014 always reads zero.
- R10: An access with address bits 1:0 not zero changes nothing and reads zero, and so does a read of an unmapped global offset. Read data appears one cycle after the request, flagged by `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| chan_sel | output | NT | One-hot channel window select |
| chan_wr | output | 1 | Channel access is a write |
| chan_word | output | 3 | Word index within channel window |
| chan_wdata | output | 32 | Channel write data |
| chan_rdata | input | NT*32 | Per-channel read data, channel 0 in low bits |
| chan_irq_set | input | NT | Per-channel status set requests |
| chan_cmp_max | input | NT | Channel comparator is all ones |
| chan_rearm | output | NT | One-cycle re-arm request |
| chan_irq_clr | output | NT | One-cycle interrupt deassert request |
| irq_status | output | NT | Interrupt status word |
| count_val | output | 64 | Main counter value |
| count_en | output | 1 | Global enable |
| legacy_route | output | 1 | Legacy route configuration bit |

## Verification
The checker watches the counter on every cycle. It confirms that the counter steps by one on each enabled tick and stays frozen while disabled, and that the status word stays empty while disabled. It also checks that write-one-to-clear removes every written bit that is not set again in the same cycle, that the channel select is never more than one-hot, and that re-arm pulses occur only on the enable's rising edge. The directed scenarios are needed for the rest: the exact register encodings, the carry across counter halves, the priority of a write over a tick, the read data of a channel window, out-of-range channels, misaligned accesses, and which channels receive a re-arm.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 64;
  localparam int MIN_TMR = 3;
  localparam int SLOT_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI = 10'h014;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 10'h020;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] OFS_WIN    = 10'h100;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LEG_BIT = 1;

  typedef struct packed {
    logic cap_lo;
    logic cap_hi;
    logic cfg_lo;
    logic cfg_hi;
    logic stat;
    logic cnt_lo;
    logic cnt_hi;
    logic win;
  } reg_hit_t;

  function automatic int clamp_timers(input int req, input int max_t);
    int r;
    r = req;
    if (r < MIN_TMR) r = MIN_TMR;
    if (r > max_t) r = max_t;
    return r;
  endfunction
endpackage

// File: rtl/evtmr_rst_sync.sv
module evtmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/evtmr_addr_decode.sv
module evtmr_addr_decode
  import evtmr_pkg::*;
#(
  parameter int NT = 3
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit,
  output logic [NT-1:0]     chan_sel,
  output logic [2:0]        chan_word
);
  localparam int WIN_BASE_SLOT = int'(OFS_WIN) >> 5;

  logic              aligned;
  logic              acc;
  logic [SLOT_W-1:0] slot;

  assign aligned = (addr[1:0] == 2'b00);
  assign acc     = sel && aligned;
  assign slot    = addr[ADDR_W-1:5] - SLOT_W'(WIN_BASE_SLOT);

  always_comb begin
    hit        = '0;
    hit.cap_lo = acc && (addr == OFS_CAP_LO);
    hit.cap_hi = acc && (addr == OFS_CAP_HI);
    hit.cfg_lo = acc && (addr == OFS_CFG_LO);
    hit.cfg_hi = acc && (addr == OFS_CFG_HI);
    hit.stat   = acc && (addr == OFS_STAT);
    hit.cnt_lo = acc && (addr == OFS_CNT_LO);
    hit.cnt_hi = acc && (addr == OFS_CNT_HI);
    hit.win    = acc && (addr >= OFS_WIN);
  end

  assign chan_word = addr[4:2];

  for (genvar gi = 0; gi < NT; gi++) begin : g_sel
    assign chan_sel[gi] = hit.win && (slot == SLOT_W'(gi));
  end
endmodule

// File: rtl/evtmr_main_counter.sv
module evtmr_main_counter
  import evtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d = cnt_q;
    if (run && tick) cnt_d = cnt_q + CNT_W'(1);
    if (wr_lo)       cnt_d = {cnt_q[CNT_W-1:HALF], wdata};
    if (wr_hi)       cnt_d = {wdata, cnt_q[HALF-1:0]};
  end

  assign cnt_ce = (run && tick) || wr_lo || wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/evtmr_status_reg.sv
module evtmr_status_reg #(
  parameter int NT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          run_fall,
  input  logic          wr_clr,
  input  logic [NT-1:0] clr_mask,
  input  logic [NT-1:0] set_req,
  output logic [NT-1:0] status,
  output logic [NT-1:0] clr_pulse
);
  logic [NT-1:0] stat_q, stat_d;
  logic [NT-1:0] pulse_q, pulse_d;
  logic [NT-1:0] wclr;

  assign wclr = wr_clr ? (clr_mask & stat_q) : '0;

  always_comb begin
    if (run_fall || !run) begin
      stat_d  = '0;
      pulse_d = stat_q;
    end else begin
      stat_d  = (stat_q & ~wclr) | set_req;
      pulse_d = wclr & ~set_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      pulse_q <= '0;
    end else begin
      stat_q  <= stat_d;
      pulse_q <= pulse_d;
    end
  end

  assign status    = stat_q;
  assign clr_pulse = pulse_q;
endmodule

// File: rtl/evtmr_global_regs.sv
module evtmr_global_regs
  import evtmr_pkg::*;
#(
  parameter int          NUM_TIMERS = 4,
  parameter int          MAX_TIMERS = 24,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000,
  parameter logic [15:0] VENDOR_ID  = 16'h5A5A,
  parameter logic [7:0]  REVISION   = 8'h01,
  localparam int         NT         = clamp_timers(NUM_TIMERS, MAX_TIMERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [NT-1:0]     chan_sel,
  output logic              chan_wr,
  output logic [2:0]        chan_word,
  output logic [DATA_W-1:0] chan_wdata,
  input  logic [NT*32-1:0]  chan_rdata,
  input  logic [NT-1:0]     chan_irq_set,
  input  logic [NT-1:0]     chan_cmp_max,
  output logic [NT-1:0]     chan_rearm,
  output logic [NT-1:0]     chan_irq_clr,
  output logic [NT-1:0]     irq_status,
  output logic [CNT_W-1:0]  count_val,
  output logic              count_en,
  output logic              legacy_route
);
  localparam int HALF = CNT_W / 2;
  localparam logic [DATA_W-1:0] CAP_LO_WORD =
    {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NT - 1), REVISION};

  logic          rst_ns;
  reg_hit_t      hit;
  logic          wr_any, rd_any;
  logic [1:0]    cfg_q, cfg_d;
  logic          run_rise, run_fall;
  logic [NT-1:0] rearm_q, rearm_d;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic [DATA_W-1:0] win_rd;
  logic          rv_q;

  evtmr_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_ns)
  );

  evtmr_addr_decode #(.NT(NT)) u_dec (
    .sel      (bus_sel),
    .addr     (bus_addr),
    .hit      (hit),
    .chan_sel (chan_sel),
    .chan_word(chan_word)
  );

  assign wr_any     = bus_sel && bus_wr;
  assign rd_any     = bus_sel && !bus_wr;
  assign chan_wr    = bus_wr;
  assign chan_wdata = bus_wdata;

  // global configuration
  always_comb begin
    cfg_d = cfg_q;
    if (hit.cfg_lo && wr_any) cfg_d = bus_wdata[1:0];
  end

  assign run_rise = cfg_d[CFG_EN_BIT] && !cfg_q[CFG_EN_BIT];
  assign run_fall = !cfg_d[CFG_EN_BIT] && cfg_q[CFG_EN_BIT];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign count_en     = cfg_q[CFG_EN_BIT];
  assign legacy_route = cfg_q[CFG_LEG_BIT];

  // re-arm request on enable rising edge
  assign rearm_d = run_rise ? ~chan_cmp_max : '0;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rearm_q <= '0;
    else         rearm_q <= rearm_d;
  end

  assign chan_rearm = rearm_q;

  evtmr_main_counter u_cnt (
    .clk  (clk),
    .rst_n(rst_ns),
    .run  (cfg_q[CFG_EN_BIT]),
    .tick (tick),
    .wr_lo(hit.cnt_lo && wr_any),
    .wr_hi(hit.cnt_hi && wr_any),
    .wdata(bus_wdata),
    .count(count_val)
  );

  evtmr_status_reg #(.NT(NT)) u_stat (
    .clk      (clk),
    .rst_n    (rst_ns),
    .run      (cfg_q[CFG_EN_BIT]),
    .run_fall (run_fall),
    .wr_clr   (hit.stat && wr_any),
    .clr_mask (bus_wdata[NT-1:0]),
    .set_req  (chan_irq_set),
    .status   (irq_status),
    .clr_pulse(chan_irq_clr)
  );

  // channel window read select
  always_comb begin
    win_rd = '0;
    for (int i = 0; i < NT; i++) begin
      if (chan_sel[i]) win_rd = chan_rdata[i*32 +: 32];
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (1'b1)
      hit.cap_lo: rd_d = CAP_LO_WORD;
      hit.cap_hi: rd_d = TICK_FS;
      hit.cfg_lo: rd_d = DATA_W'(cfg_q);
      hit.cfg_hi: rd_d = '0;
      hit.stat:   rd_d = DATA_W'(irq_status);
      hit.cnt_lo: rd_d = count_val[HALF-1:0];
      hit.cnt_hi: rd_d = count_val[CNT_W-1:HALF];
      hit.win:    rd_d = win_rd;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= rd_any;
      if (rd_any) rd_q <= rd_d;
    end
  end

  assign bus_rdata  = rd_q;
  assign bus_rvalid = rv_q;
endmodule

// File: rtl/evtmr_global_regs_chk.sv
module evtmr_global_regs_chk #(
  parameter int NT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [9:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [NT-1:0] chan_sel,
  input logic [NT-1:0] chan_irq_set,
  input logic [NT-1:0] chan_rearm,
  input logic [NT-1:0] irq_status,
  input logic [63:0]   count_val,
  input logic          count_en
);
  logic cnt_wr;
  logic stat_wr;
  assign cnt_wr  = bus_sel && bus_wr && (bus_addr == 10'h0F0 || bus_addr == 10'h0F4);
  assign stat_wr = bus_sel && bus_wr && (bus_addr == 10'h020);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && tick && !cnt_wr) |=> (count_val == $past(count_val) + 64'd1)); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !cnt_wr) |=> $stable(count_val)); // R3

  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && count_en) |=> ((irq_status & $past(bus_wdata[NT-1:0] & ~chan_irq_set)) == '0)); // R5

  AST_OFF_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |-> (irq_status == '0)); // R6

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel)); // R7

  AST_REARM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rearm != '0) |-> (count_en && !$past(count_en))); // R8
endmodule

bind evtmr_global_regs evtmr_global_regs_chk #(.NT(NT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .chan_sel    (chan_sel),
  .chan_irq_set(chan_irq_set),
  .chan_rearm  (chan_rearm),
  .irq_status  (irq_status),
  .count_val   (count_val),
  .count_en    (count_en)
);

// File: tb/evtmr_global_regs_bench.sv
module evtmr_global_regs_bench;
  localparam int NT = 4;
  localparam logic [31:0] TFS = 32'd10_000_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [9:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NT-1:0] chan_sel;
  logic          chan_wr;
  logic [2:0]    chan_word;
  logic [31:0]   chan_wdata;
  logic [NT*32-1:0] chan_rdata;
  logic [NT-1:0] chan_irq_set = '0;
  logic [NT-1:0] chan_cmp_max = '0;
  logic [NT-1:0] chan_rearm;
  logic [NT-1:0] chan_irq_clr;
  logic [NT-1:0] irq_status;
  logic [63:0]   count_val;
  logic          count_en;
  logic          legacy_route;

  int total = 0;
  int bad = 0;
  logic [NT-1:0] sel_seen;
  logic          wr_seen;
  logic [31:0]   rd;

  always #4 clk = ~clk;

  for (genvar gi = 0; gi < NT; gi++) begin : g_model
    assign chan_rdata[gi*32 +: 32] = 32'hC0DE_0000 | (32'(gi) << 8) | 32'(chan_word);
  end

  evtmr_global_regs #(.NUM_TIMERS(NT), .TICK_FS(TFS)) u_evtmr_global_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .chan_sel(chan_sel), .chan_wr(chan_wr), .chan_word(chan_word), .chan_wdata(chan_wdata),
    .chan_rdata(chan_rdata), .chan_irq_set(chan_irq_set), .chan_cmp_max(chan_cmp_max),
    .chan_rearm(chan_rearm), .chan_irq_clr(chan_irq_clr), .irq_status(irq_status),
    .count_val(count_val), .count_en(count_en), .legacy_route(legacy_route)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #2;
    sel_seen = chan_sel; wr_seen = chan_wr;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    sel_seen = chan_sel;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    check("R10 rvalid", 64'(bus_rvalid), 64'd1);
  endtask

  task automatic run_ticks(input int k);
    tick = 1'b1;
    repeat (k) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    bus_read(10'h0F0, rd); check("R1 cnt lo", 64'(rd), 64'd0);
    bus_read(10'h0F4, rd); check("R1 cnt hi", 64'(rd), 64'd0);
    bus_read(10'h010, rd); check("R1 cfg", 64'(rd), 64'd0);
    bus_read(10'h020, rd); check("R1 status", 64'(rd), 64'd0);
    check("R1 pins", {60'd0, count_en, legacy_route, |chan_rearm, |chan_irq_clr}, 64'd0);
  endtask

  task automatic t_capability;
    logic [31:0] exp_lo;
    exp_lo = {16'h5A5A, 1'b1, 1'b0, 1'b1, 5'(NT - 1), 8'h01};
    bus_read(10'h000, rd); check("R9 cap lo", 64'(rd), 64'(exp_lo));
    bus_read(10'h004, rd); check("R9 period", 64'(rd), 64'(TFS));
    bus_write(10'h000, 32'h1234_5678);
    bus_write(10'h004, 32'h0);
    bus_read(10'h000, rd); check("R9 cap lo after write", 64'(rd), 64'(exp_lo));
    bus_read(10'h004, rd); check("R9 period after write", 64'(rd), 64'(TFS));
    bus_write(10'h014, 32'hFFFF_FFFF);
    bus_read(10'h014, rd); check("R9 cfg hi", 64'(rd), 64'd0);
  endtask

  task automatic t_count_carry;
    bus_write(10'h0F0, 32'hFFFF_FFFE);
    bus_write(10'h0F4, 32'h0000_0012);
    bus_write(10'h010, 32'h1);
    run_ticks(5);
    bus_read(10'h0F0, rd); check("R2 lo after carry", 64'(rd), 64'h3);
    bus_read(10'h0F4, rd); check("R2 hi after carry", 64'(rd), 64'h13);
  endtask

  task automatic t_hold_resume;
    bus_write(10'h010, 32'h0);
    run_ticks(7);
    check("R3 held port", count_val, 64'h13_0000_0003);
    bus_read(10'h0F0, rd); check("R3 held read", 64'(rd), 64'h3);
    bus_write(10'h010, 32'h1);
    run_ticks(2);
    check("R3 resumed", count_val, 64'h13_0000_0005);
  endtask

  task automatic t_write_priority;
    tick = 1'b1;
    bus_write(10'h0F0, 32'h0000_0100);
    check("R4 write beats tick", count_val, 64'h13_0000_0100);
    @(negedge clk);
    check("R4 counts after write", count_val, 64'h13_0000_0101);
    tick = 1'b0;
    bus_write(10'h0F4, 32'hA);
    check("R4 hi write keeps lo", count_val, 64'hA_0000_0101);
  endtask

  task automatic t_status;
    @(negedge clk); chan_irq_set = 4'b1011;
    @(negedge clk); chan_irq_set = '0;
    check("R5 status set", 64'(irq_status), 64'b1011);
    bus_write(10'h020, 32'h6);
    check("R5 w1c", 64'(irq_status), 64'b1001);
    check("R5 clr pulse", 64'(chan_irq_clr), 64'b0010);
    @(negedge clk);
    check("R5 pulse one cycle", 64'(chan_irq_clr), 64'd0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h020; bus_wdata = 32'h1; chan_irq_set = 4'b0001;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; chan_irq_set = '0;
    check("R5 set wins", 64'(irq_status), 64'b1001);
  endtask

  task automatic t_disable;
    bus_write(10'h010, 32'h0);
    check("R6 cleared", 64'(irq_status), 64'd0);
    check("R6 clr pulse", 64'(chan_irq_clr), 64'b1001);
    @(negedge clk); chan_irq_set = 4'b1111;
    @(negedge clk); chan_irq_set = '0;
    check("R6 ignored when off", 64'(irq_status), 64'd0);
  endtask

  task automatic t_window;
    bus_read(10'h148, rd);
    check("R7 sel ch2", 64'(sel_seen), 64'b0100);
    check("R7 rdata ch2", 64'(rd), 64'hC0DE_0202);
    bus_read(10'h100, rd);
    check("R7 rdata ch0", 64'(rd), 64'hC0DE_0000);
    bus_write(10'h174, 32'h55);
    check("R7 write sel ch3", {59'd0, sel_seen, wr_seen}, {59'd0, 4'b1000, 1'b1});
    bus_read(10'h180, rd);
    check("R7 oor sel", 64'(sel_seen), 64'd0);
    check("R7 oor read", 64'(rd), 64'd0);
  endtask

  task automatic t_rearm;
    chan_cmp_max = 4'b0100;
    bus_write(10'h010, 32'h3);
    check("R8 rearm", 64'(chan_rearm), 64'b1011);
    check("R8 legacy", 64'(legacy_route), 64'd1);
    @(negedge clk);
    check("R8 rearm one cycle", 64'(chan_rearm), 64'd0);
    bus_write(10'h010, 32'h1);
    check("R8 no rearm while on", 64'(chan_rearm), 64'd0);
    chan_cmp_max = '0;
  endtask

  task automatic t_misaligned;
    bus_write(10'h0F1, 32'hDEAD_BEEF);
    check("R10 misaligned write", count_val, 64'hA_0000_0101);
    bus_read(10'h0F1, rd); check("R10 misaligned read", 64'(rd), 64'd0);
    bus_read(10'h080, rd); check("R10 unmapped read", 64'(rd), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_capability();
    t_count_carry();
    t_hold_resume();
    t_write_priority();
    t_status();
    t_disable();
    t_window();
    t_rearm();
    t_misaligned();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule